// File: doc/BRIEF.md
# Masked Configuration Register Space

This block holds the 256-byte configuration register space of one device on a shared expansion bus. The lower 64 bytes form the standard header: identity fields, a command register, six base-address slots, an expansion ROM slot and interrupt routing. The upper 192 bytes are free device-specific storage. A bus front end, which is outside this block, turns configuration cycles into single-cycle read and write requests carrying a byte offset, a length code and up to four data bytes.

Every byte has a write mask fixed at elaboration. A write merges the new data into each addressed byte only where the mask allows it. Identity bytes therefore stay constant. A base-address slot keeps its low bits at zero, so software can size the window it decodes. Reads return little-endian data one cycle after the request. A read that would run past the end of the space is rejected and returns all ones.

When a write changes anything that affects address decoding, the block raises a one-cycle remap pulse. This covers any base-address byte and the I/O or memory decode enable bits. The decoder downstream uses the pulse to load the new windows again.

Top module: `cfg_space`

## Requirements
- R1: After reset, the vendor identifier (offset 0x00), device identifier (0x02), revision (0x08) and 24-bit class code (0x09) hold their parameter values in little-endian order. The interrupt pin byte (0x3D) holds its parameter value. Every other byte reads zero.
- R2: A read request with length code 0 returns 1 byte and code 1 returns 2 bytes; codes 2 and 3 both return 4 bytes. The byte at the lowest offset goes in bits 7:0, and unused upper bits are zero. rdValid is high in the cycle after rdEn, for that cycle only.
- R3: A 4-byte read at an offset above 0xFC, or a 2-byte read at an offset above 0xFE, returns 0xFFFFFFFF with rdValid.
- R4: A write changes each addressed byte to (old AND NOT mask) OR (new AND mask). Data bits 7:0 go to the lowest offset, and the new value can be read from the next cycle onward.
- R5: In the header, only three things are writable: the cache-line-size byte (0x0C), the interrupt-line byte (0x3C), and bits 2:0 of the command byte (0x04: I/O decode enable, memory decode enable, bus master). All other header bytes outside the base-address and ROM slots are read-only.
- R6: Bytes 0x40 to 0xFF are writable in all bits.
- R7: Base-address slot i occupies offsets 0x10+4i to 0x13+4i. Its 32-bit write mask is NOT(2^BAR_LOG2[i] - 1). A slot with a log2 size of 0 is absent and reads zero.
- R8: The expansion ROM slot at offset 0x30 uses the mask NOT(2^ROM_LOG2 - 1) OR 1, so bit 0 (the ROM enable) is writable.
- R9: Write lanes whose offset would pass 0xFF are dropped and do not wrap to 0x00.
- R10: remapPulse is high for exactly the cycle after a write that changes a value in one of two places: any byte from 0x10 to 0x27, or command bits 0 or 1.
- R11: remapPulse stays low after reads and idle cycles. It also stays low after writes whose only changes fall outside the remap set, such as the bus-master bit, the ROM slot or device-specific bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write request for this cycle |
| rdEn | input | 1 | Read request for this cycle |
| addr | input | 8 | Byte offset of the access |
| lenCode | input | 2 | Access length: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| wrData | input | 32 | Write data, little-endian |
| rdData | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read result strobe, one cycle after rdEn |
| remapPulse | output | 1 | One-cycle pulse after a decode-relevant change |

## Verification
A wrong mask bit or a wrong reset byte shows up on the next read that covers that byte. A bad merge or a mis-steered lane shows up there too. The fault appears as a data mismatch one cycle after the read request. A missing or false change detection shows up in remapPulse one cycle after the write, so each write is followed by a check of the pulse against a model of which bytes actually changed. Lanes dropped at the top of the space are checked by reading back both the bytes at the end and the bytes at the start.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int SPACE_BYTES = 256;
  localparam int HDR_BYTES   = 64;
  localparam int NUM_BARS    = 6;
  localparam int LANES       = 4;
  localparam logic [7:0] OFS_CMD   = 8'h04;
  localparam logic [7:0] OFS_CLS   = 8'h0C;
  localparam logic [7:0] OFS_BAR   = 8'h10;
  localparam logic [7:0] OFS_ROM   = 8'h30;
  localparam logic [7:0] OFS_ILINE = 8'h3C;
  localparam logic [7:0] OFS_IPIN  = 8'h3D;
  localparam logic [7:0] REMAP_LO  = OFS_BAR;
  localparam logic [7:0] REMAP_HI  = 8'(OFS_BAR + 4*NUM_BARS - 1);
  localparam logic [7:0] CMD_WMASK = 8'h07;
  localparam logic [7:0] CMD_DECODE = 8'h03;

  typedef enum logic [1:0] {LEN_ONE = 2'd0, LEN_TWO = 2'd1, LEN_FOUR = 2'd2, LEN_FOURX = 2'd3} lenCode_e;

  typedef struct packed {
    logic [LANES-1:0] laneWr;
    logic [LANES-1:0] laneRd;
    logic [7:0]       base;
    logic             rdGo;
    logic             rdReject;
  } cfgStrobe_t;

  function automatic logic [31:0] sizeMask(input logic [7:0] lg);
    if (lg == 8'd0) return 32'h0;
    return ~((32'd1 << lg[4:0]) - 32'd1);
  endfunction

  function automatic logic [7:0] cfgMask(input logic [7:0] a,
                                         input logic [8*NUM_BARS-1:0] barLog2,
                                         input logic [7:0] romLog2);
    logic [31:0] m;
    int slot;
    if (a >= 8'(HDR_BYTES)) return 8'hFF;
    if (a == OFS_CMD) return CMD_WMASK;
    if (a == OFS_CLS || a == OFS_ILINE) return 8'hFF;
    if (a >= REMAP_LO && a <= REMAP_HI) begin
      slot = int'(a - OFS_BAR) >> 2;
      m = sizeMask(barLog2[slot*8 +: 8]);
      return m[8*a[1:0] +: 8];
    end
    if (a >= OFS_ROM && a < 8'(OFS_ROM + 4)) begin
      m = (romLog2 == 8'd0) ? 32'h0 : (sizeMask(romLog2) | 32'h1);
      return m[8*a[1:0] +: 8];
    end
    return 8'h00;
  endfunction

  function automatic logic [7:0] cfgReset(input logic [7:0] a, input logic [15:0] vend,
                                          input logic [15:0] dev, input logic [7:0] rev,
                                          input logic [23:0] cls, input logic [7:0] pin);
    case (a)
      8'h00: return vend[7:0];
      8'h01: return vend[15:8];
      8'h02: return dev[7:0];
      8'h03: return dev[15:8];
      8'h08: return rev;
      8'h09: return cls[7:0];
      8'h0A: return cls[15:8];
      8'h0B: return cls[23:16];
      OFS_IPIN: return pin;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_pkg::*;
(
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] addr,
  input  logic [1:0] lenCode,
  output cfgStrobe_t strobe
);
  logic [2:0] nBytes;
  logic [8:0] lastOfs;

  always_comb begin
    case (lenCode_e'(lenCode))
      LEN_ONE: nBytes = 3'd1;
      LEN_TWO: nBytes = 3'd2;
      default: nBytes = 3'd4;
    endcase
    lastOfs = {1'b0, addr} + 9'(nBytes) - 9'd1;
  end

  always_comb begin
    strobe = '0;
    strobe.base     = addr;
    strobe.rdGo     = rdEn;
    strobe.rdReject = rdEn && lastOfs[8];
    for (int k = 0; k < LANES; k++) begin
      logic [8:0] ofs;
      ofs = {1'b0, addr} + 9'(k);
      strobe.laneWr[k] = wrEn && (3'(k) < nBytes) && !ofs[8];
      strobe.laneRd[k] = rdEn && (3'(k) < nBytes);
    end
  end
endmodule

// File: rtl/cfg_data.sv
module cfg_data
  import cfg_pkg::*;
#(
  parameter logic [8*NUM_BARS-1:0] BAR_LOG2 = '0,
  parameter logic [7:0]  ROM_LOG2   = 8'd0,
  parameter logic [15:0] VENDOR_ID  = 16'h0,
  parameter logic [15:0] DEVICE_ID  = 16'h0,
  parameter logic [7:0]  REV_ID     = 8'h0,
  parameter logic [23:0] CLASS_CODE = 24'h0,
  parameter logic [7:0]  INT_PIN    = 8'h0
) (
  input  logic        clk,
  input  logic        rstN,
  input  cfgStrobe_t  strobe,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        rdValid,
  output logic        remapPulse
);
  logic [7:0] regs    [SPACE_BYTES];
  logic [7:0] maskArr [SPACE_BYTES];
  logic [7:0] rstArr  [SPACE_BYTES];
  logic [7:0] byteDat [SPACE_BYTES];
  logic [SPACE_BYTES-1:0] byteWe;
  logic [SPACE_BYTES-1:0] byteChg;
  logic remapNext;
  logic [31:0] rdNext;

  always_comb begin
    for (int j = 0; j < SPACE_BYTES; j++) begin
      maskArr[j] = cfgMask(8'(j), BAR_LOG2, ROM_LOG2);
      rstArr[j]  = cfgReset(8'(j), VENDOR_ID, DEVICE_ID, REV_ID, CLASS_CODE, INT_PIN);
    end
  end

  // lane steering: lane k lands on offset base+k
  always_comb begin
    for (int j = 0; j < SPACE_BYTES; j++) begin
      byteWe[j]  = 1'b0;
      byteDat[j] = 8'h00;
      for (int k = 0; k < LANES; k++) begin
        if (strobe.laneWr[k] && (8'(strobe.base + 8'(k)) == 8'(j))) begin
          byteWe[j]  = 1'b1;
          byteDat[j] = wrData[8*k +: 8];
        end
      end
      byteChg[j] = byteWe[j] && (((regs[j] ^ byteDat[j]) & maskArr[j]) != 8'h00);
    end
  end

  always_comb begin
    remapNext = byteWe[OFS_CMD] &&
                (((regs[OFS_CMD] ^ byteDat[OFS_CMD]) & maskArr[OFS_CMD] & CMD_DECODE) != 8'h00);
    for (int j = int'(REMAP_LO); j <= int'(REMAP_HI); j++) begin
      remapNext = remapNext | byteChg[j];
    end
  end

  always_comb begin
    rdNext = 32'h0;
    if (strobe.rdReject) begin
      rdNext = 32'hFFFF_FFFF;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (strobe.laneRd[k]) rdNext[8*k +: 8] = regs[8'(strobe.base + 8'(k))];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < SPACE_BYTES; j++) regs[j] <= rstArr[j];
      rdData     <= 32'h0;
      rdValid    <= 1'b0;
      remapPulse <= 1'b0;
    end else begin
      for (int j = 0; j < SPACE_BYTES; j++) begin
        if (byteWe[j]) regs[j] <= (regs[j] & ~maskArr[j]) | (byteDat[j] & maskArr[j]);
      end
      rdValid    <= strobe.rdGo;
      remapPulse <= remapNext;
      if (strobe.rdGo) rdData <= rdNext;
    end
  end
endmodule

// File: rtl/cfg_space.sv
module cfg_space
  import cfg_pkg::*;
#(
  parameter logic [8*NUM_BARS-1:0] BAR_LOG2 = {8'd0, 8'd0, 8'd0, 8'd0, 8'd8, 8'd12},
  parameter logic [7:0]  ROM_LOG2   = 8'd16,
  parameter logic [15:0] VENDOR_ID  = 16'hA51C,
  parameter logic [15:0] DEVICE_ID  = 16'h3E07,
  parameter logic [7:0]  REV_ID     = 8'h02,
  parameter logic [23:0] CLASS_CODE = 24'h020000,
  parameter logic [7:0]  INT_PIN    = 8'h01
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  addr,
  input  logic [1:0]  lenCode,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        rdValid,
  output logic        remapPulse
);
  cfgStrobe_t strobe;

  cfg_ctrl ctrl_i (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .lenCode(lenCode), .strobe(strobe)
  );

  cfg_data #(
    .BAR_LOG2(BAR_LOG2), .ROM_LOG2(ROM_LOG2), .VENDOR_ID(VENDOR_ID),
    .DEVICE_ID(DEVICE_ID), .REV_ID(REV_ID), .CLASS_CODE(CLASS_CODE), .INT_PIN(INT_PIN)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .remapPulse(remapPulse)
  );
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
  parameter logic [15:0] VENDOR_ID = 16'h0
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        rdEn,
  input logic [7:0]  addr,
  input logic [1:0]  lenCode,
  input logic [31:0] rdData,
  input logic        rdValid,
  input logic        remapPulse
);
  AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid); // R2
  AST_RD_VALID_CAUSED: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn)); // R2
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && lenCode == 2'd0) |=> (rdData[31:8] == 24'h0)); // R2
  AST_REJECT_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && lenCode[1] && addr > 8'hFC) |=> (rdData == 32'hFFFF_FFFF)); // R3
  AST_VENDOR_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && lenCode == 2'd1 && addr == 8'h00) |=> (rdData == {16'h0, VENDOR_ID})); // R5
  AST_REMAP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    remapPulse |-> $past(wrEn)); // R11
endmodule

bind cfg_space cfg_space_chk #(.VENDOR_ID(VENDOR_ID)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .lenCode(lenCode),
  .rdData(rdData), .rdValid(rdValid), .remapPulse(remapPulse)
);

// File: tb/cfg_space_tb_top.sv
module cfg_space_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] addr = 8'h0;
  logic [1:0] lenCode = 2'd0;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData;
  logic rdValid, remapPulse;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [7:0] mdl [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_space dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .lenCode(lenCode),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .remapPulse(remapPulse)
  );

  // write masks for the default parameters, from the requirements
  function automatic logic [7:0] benchMask(input int a);
    if (a >= 64) return 8'hFF;                        // R6
    if (a == 12 || a == 60) return 8'hFF;             // R5
    if (a == 4) return 8'h07;                         // R5
    if (a == 16) return 8'h00;                        // R7 BAR0 4 KiB
    if (a == 17) return 8'hF0;
    if (a == 18 || a == 19) return 8'hFF;
    if (a == 20) return 8'h00;                        // R7 BAR1 256 B
    if (a >= 21 && a <= 23) return 8'hFF;
    if (a == 48) return 8'h01;                        // R8 ROM 64 KiB
    if (a == 49) return 8'h00;
    if (a == 50 || a == 51) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] benchReset(input int a);
    case (a)
      0: return 8'h1C; 1: return 8'hA5; 2: return 8'h07; 3: return 8'h3E;
      8: return 8'h02; 9: return 8'h00; 10: return 8'h00; 11: return 8'h02;
      61: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int lenBytes(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] expRead(input int a, input logic [1:0] c);
    logic [31:0] v;
    int n;
    n = lenBytes(c);
    if (a + n - 1 > 255) return 32'hFFFF_FFFF;
    v = 32'h0;
    for (int k = 0; k < n; k++) v[8*k +: 8] = mdl[a + k];
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic doRead(input string req, input logic [7:0] a, input logic [1:0] c);
    logic [31:0] e;
    e = expRead(int'(a), c);
    @(negedge clk);
    rdEn = 1'b1; addr = a; lenCode = c;
    @(negedge clk);
    rdEn = 1'b0;
    check({req, " rdValid"}, {31'h0, rdValid}, 32'h1);
    check(req, rdData, e);
    check({req, " R11 no pulse on read"}, {31'h0, remapPulse}, 32'h0);
  endtask

  task automatic doWrite(input string req, input logic [7:0] a, input logic [1:0] c,
                         input logic [31:0] d);
    int n;
    bit expPulse;
    logic [7:0] nb;
    n = lenBytes(c);
    expPulse = 1'b0;
    for (int k = 0; k < n; k++) begin
      int o;
      o = int'(a) + k;
      if (o <= 255) begin
        nb = (mdl[o] & ~benchMask(o)) | (d[8*k +: 8] & benchMask(o));
        if (nb != mdl[o] && o >= 16 && o <= 39) expPulse = 1'b1;
        if (o == 4 && ((nb ^ mdl[o]) & 8'h03) != 8'h00) expPulse = 1'b1;
        mdl[o] = nb;
      end
    end
    @(negedge clk);
    wrEn = 1'b1; addr = a; lenCode = c; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    check({req, " R10/R11 remapPulse"}, {31'h0, remapPulse}, {31'h0, expPulse});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int j = 0; j < 256; j++) mdl[j] = benchReset(j);
    repeat (3) @(negedge clk);
    check("R1 reset rdValid", {31'h0, rdValid}, 32'h0);
    check("R10 reset remapPulse", {31'h0, remapPulse}, 32'h0);
    rstN = 1'b1;

    // R1 reset image of the header plus a few upper bytes
    for (int a = 0; a < 64; a += 4) doRead("R1 reset header", 8'(a), 2'd2);
    doRead("R1 reset upper", 8'h80, 2'd2);
    doRead("R1 reset last", 8'hFC, 2'd3);

    // R2 widths and lane order
    doRead("R2 byte read", 8'h01, 2'd0);
    doRead("R2 half read", 8'h02, 2'd1);
    doRead("R2 half odd offset", 8'h09, 2'd1);

    // R5 identity fixed, command bits, cache line, interrupt line
    doWrite("R5 identity write", 8'h00, 2'd2, 32'hFFFF_FFFF);
    doRead("R5 identity kept", 8'h00, 2'd2);
    doWrite("R5 command write", 8'h04, 2'd1, 32'hFFFF);
    doRead("R5 command bits", 8'h04, 2'd2);
    @(negedge clk);
    check("R10 pulse one cycle", {31'h0, remapPulse}, 32'h0);
    doWrite("R11 same command", 8'h04, 2'd0, 32'h07);
    doWrite("R11 bus master only", 8'h04, 2'd0, 32'h03);
    doWrite("R10 memory enable off", 8'h04, 2'd0, 32'h01);
    doWrite("R5 cache line", 8'h0C, 2'd2, 32'hFFFF_FFFF);
    doRead("R5 cache line read", 8'h0C, 2'd2);
    doWrite("R5 interrupt line", 8'h3C, 2'd2, 32'hFFFF_FFFF);
    doRead("R5 interrupt line read", 8'h3C, 2'd2);

    // R7 base-address slots, R8 ROM slot
    doWrite("R7 BAR0 sizing", 8'h10, 2'd2, 32'hFFFF_FFFF);
    doRead("R7 BAR0 readback", 8'h10, 2'd2);
    doWrite("R7 BAR1 sizing", 8'h14, 2'd2, 32'hFFFF_FFFF);
    doRead("R7 BAR1 readback", 8'h14, 2'd2);
    doWrite("R7 BAR2 absent", 8'h18, 2'd2, 32'hFFFF_FFFF);
    doRead("R7 BAR2 readback", 8'h18, 2'd2);
    doWrite("R10 BAR0 same value", 8'h10, 2'd2, 32'hFFFF_FFFF);
    doWrite("R8 ROM sizing", 8'h30, 2'd2, 32'hFFFF_FFFF);
    doRead("R8 ROM readback", 8'h30, 2'd2);

    // R4 R6 lane order and upper region
    doWrite("R4 lane order", 8'h80, 2'd2, 32'h1122_3344);
    doRead("R4 lowest lane", 8'h80, 2'd0);
    doRead("R6 upper dword", 8'h80, 2'd2);
    doWrite("R4 merge partial", 8'h81, 2'd1, 32'hBEEF);
    doRead("R4 merge readback", 8'h80, 2'd2);

    // R9 lanes past the end, R3 rejected reads
    doWrite("R9 write at 0xFD", 8'hFD, 2'd2, 32'hA1B2_C3D4);
    doWrite("R9 write at 0xFF", 8'hFF, 2'd1, 32'h0000_5E6F);
    doRead("R9 tail bytes", 8'hFC, 2'd2);
    doRead("R9 start intact", 8'h00, 2'd2);
    doRead("R3 dword at 0xFD", 8'hFD, 2'd2);
    doRead("R3 dword at 0xFF code3", 8'hFF, 2'd3);
    doRead("R3 half at 0xFF", 8'hFF, 2'd1);
    doRead("R3 byte at 0xFF ok", 8'hFF, 2'd0);
    doRead("R3 half at 0xFE ok", 8'hFE, 2'd1);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ra;
      logic [1:0] rc;
      ra = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 63)) : 8'($urandom_range(0, 255));
      rc = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0) doWrite("R4 random write", ra, rc, $urandom());
      else doRead("R2 random read", ra, rc);
    end
    for (int a = 0; a < 256; a += 4) doRead("R4 final sweep", 8'(a), 2'd2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule